// File: doc/BRIEF.md
# Indexed Window Bridge

This bridge gives a host access to a 28-bit internal address space through two 32-bit registers. The host does not need the full 28-bit address range on its own bus.

The host first writes an internal address into an index register. It then reads or writes a data register. Each data access is forwarded to an internal request/response port, using the address held in the latch. The latch keeps its value, so a run of data accesses goes to the same internal location until the index is rewritten.

The two top bits of the latched address and the two bits below them are brought out as a map selector and a bank number. Neighbouring logic uses these fields to steer the access. The host bus takes one access at a time. A request is accepted with a valid/ready pair, and its response is returned with a second valid/ready pair.

Top module: `idx_window_bridge`

## Requirements
- R1: After reset the latched address is zero. No host response or internal request is pending, the bridge is ready for a request, and a read of offset 0x00 returns 0.
- R2: A host write to offset 0x00 stores host data bits 27:0 as the latched address and ignores bits 31:28. A host read of offset 0x00 returns the latched address with bits 31:28 zero.
- R3: A host write to offset 0x10 issues exactly one internal request with write enable 1, the latched address and the host write data. The host response follows the internal acceptance and carries read data 0.
- R4: A host read of offset 0x10 issues exactly one internal request with write enable 0 and the latched address. The host response is held back until the internal port returns read data, and it carries that data.
- R5: Data accesses leave the latched address unchanged. Repeated data accesses go to the same internal address until offset 0x00 is written again.
- R6: The map select output equals latched address bits 27:26, and the bank output equals latched address bits 25:24.
- R7: A host access to any other offset reads as 0. A write to such an offset changes neither the latched address nor causes any internal request.
- R8: Only one access is in flight. The request ready is low from acceptance until the response is taken, and the response valid and data stay unchanged while the response ready is low.
- R9: An internal request holds its valid, address, write data and write enable unchanged until the internal ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hostReqValid | input | 1 | Host request valid |
| hostReqReady | output | 1 | Bridge can accept a host request |
| hostWrite | input | 1 | 1 = write, 0 = read |
| hostAddr | input | 8 | Window byte offset |
| hostWdata | input | 32 | Host write data |
| hostRspValid | output | 1 | Host response valid |
| hostRspReady | input | 1 | Host takes the response |
| hostRdata | output | 32 | Host response data |
| intReqValid | output | 1 | Internal request valid |
| intReqReady | input | 1 | Internal port accepts the request |
| intWe | output | 1 | Internal write enable |
| intAddr | output | 28 | Internal address (latched index) |
| intWdata | output | 32 | Internal write data |
| intRspValid | input | 1 | Internal read data valid |
| intRdata | input | 32 | Internal read data |
| mapSel | output | 2 | Access map selector, latched address bits 27:26 |
| bankSel | output | 2 | Bank number, latched address bits 25:24 |

## Verification
The assertions assume that the host raises a request only while the bridge shows ready. They also assume that the internal port returns read data only after it has accepted a read request, and never in the same cycle as the acceptance.

The bench's host tasks wait for the request ready before they drive a request. Its internal responder raises its read-data strobe a programmable number of cycles after the acceptance cycle. Internal stalls and host response stalls are varied, so that the hold rules are exercised with waits of several cycles.

// File: rtl/idx_window_pkg.sv
package idx_window_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_IWR,
    S_IRD_REQ,
    S_IRD_WAIT,
    S_RESP
  } bridge_state_e;

  typedef enum logic [1:0] {
    RD_ZERO,
    RD_ADDR,
    RD_INT
  } rd_sel_e;

  typedef struct packed {
    logic    latchAddr;
    logic    capWdata;
    logic    loadRd;
    rd_sel_e rdSel;
  } dp_strobe_t;

endpackage

// File: rtl/idx_window_ctrl.sv
module idx_window_ctrl
  import idx_window_pkg::*;
#(
  parameter int HOST_AW = 8,
  parameter logic [HOST_AW-1:0] CTRL_OFS = 'h00,
  parameter logic [HOST_AW-1:0] DATA_OFS = 'h10
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostReqValid,
  input  logic               hostWrite,
  input  logic [HOST_AW-1:0] hostAddr,
  output logic               hostReqReady,
  output logic               hostRspValid,
  input  logic               hostRspReady,
  output logic               intReqValid,
  output logic               intWe,
  input  logic               intReqReady,
  input  logic               intRspValid,
  output dp_strobe_t         st
);

  bridge_state_e stateQ, stateD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= S_IDLE;
    else       stateQ <= stateD;
  end

  assign hostReqReady = (stateQ == S_IDLE);
  assign hostRspValid = (stateQ == S_RESP);
  assign intReqValid  = (stateQ == S_IWR) || (stateQ == S_IRD_REQ);
  assign intWe        = (stateQ == S_IWR);

  always_comb begin
    stateD       = stateQ;
    st.latchAddr = 1'b0;
    st.capWdata  = 1'b0;
    st.loadRd    = 1'b0;
    st.rdSel     = RD_ZERO;
    unique case (stateQ)
      S_IDLE: begin
        if (hostReqValid) begin
          if (hostAddr == CTRL_OFS) begin
            st.loadRd    = 1'b1;
            st.rdSel     = hostWrite ? RD_ZERO : RD_ADDR;
            st.latchAddr = hostWrite;
            stateD       = S_RESP;
          end else if (hostAddr == DATA_OFS) begin
            st.capWdata = hostWrite;
            stateD      = hostWrite ? S_IWR : S_IRD_REQ;
          end else begin
            st.loadRd = 1'b1;
            st.rdSel  = RD_ZERO;
            stateD    = S_RESP;
          end
        end
      end
      S_IWR: begin
        if (intReqReady) begin
          st.loadRd = 1'b1;
          st.rdSel  = RD_ZERO;
          stateD    = S_RESP;
        end
      end
      S_IRD_REQ: begin
        if (intReqReady) stateD = S_IRD_WAIT;
      end
      S_IRD_WAIT: begin
        if (intRspValid) begin
          st.loadRd = 1'b1;
          st.rdSel  = RD_INT;
          stateD    = S_RESP;
        end
      end
      S_RESP: begin
        if (hostRspReady) stateD = S_IDLE;
      end
      default: stateD = S_IDLE;
    endcase
  end

  // R8: while the bridge accepts requests nothing else is in flight
  p_single_access_r8: assert property (@(posedge clk) disable iff (!rstN)
    hostReqReady |-> (!hostRspValid && !intReqValid));

  // R8: a pending response is not dropped before it is taken
  p_rsp_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (hostRspValid && !hostRspReady) |=> hostRspValid);

endmodule

// File: rtl/idx_window_dp.sv
module idx_window_dp
  import idx_window_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int INT_AW = 28
) (
  input  logic              clk,
  input  logic              rstN,
  input  dp_strobe_t        st,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic [DATA_W-1:0] intRdata,
  output logic [INT_AW-1:0] addrQ,
  output logic [DATA_W-1:0] wdataQ,
  output logic [DATA_W-1:0] rdataQ
);

  logic [DATA_W-1:0] rdNext;

  always_comb begin
    unique case (st.rdSel)
      RD_ADDR: rdNext = DATA_W'(addrQ);
      RD_INT:  rdNext = intRdata;
      default: rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      rdataQ <= '0;
    end else begin
      if (st.latchAddr) addrQ  <= hostWdata[INT_AW-1:0];
      if (st.capWdata)  wdataQ <= hostWdata;
      if (st.loadRd)    rdataQ <= rdNext;
    end
  end

  // R5: the index only moves on a control-register write strobe
  p_latch_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !st.latchAddr |=> $stable(addrQ));

endmodule

// File: rtl/idx_window_bridge.sv
module idx_window_bridge
  import idx_window_pkg::*;
#(
  parameter int HOST_AW  = 8,
  parameter int DATA_W   = 32,
  parameter int INT_AW   = 28,
  parameter int MAP_LSB  = 26,
  parameter int BANK_LSB = 24,
  parameter logic [HOST_AW-1:0] CTRL_OFS = 'h00,
  parameter logic [HOST_AW-1:0] DATA_OFS = 'h10,
  localparam int MAP_W  = INT_AW - MAP_LSB,
  localparam int BANK_W = MAP_LSB - BANK_LSB
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostReqValid,
  output logic               hostReqReady,
  input  logic               hostWrite,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic [DATA_W-1:0]  hostWdata,
  output logic               hostRspValid,
  input  logic               hostRspReady,
  output logic [DATA_W-1:0]  hostRdata,
  output logic               intReqValid,
  input  logic               intReqReady,
  output logic               intWe,
  output logic [INT_AW-1:0]  intAddr,
  output logic [DATA_W-1:0]  intWdata,
  input  logic               intRspValid,
  input  logic [DATA_W-1:0]  intRdata,
  output logic [MAP_W-1:0]   mapSel,
  output logic [BANK_W-1:0]  bankSel
);

  dp_strobe_t        st;
  logic [INT_AW-1:0] addrQ;

  idx_window_ctrl #(
    .HOST_AW (HOST_AW),
    .CTRL_OFS(CTRL_OFS),
    .DATA_OFS(DATA_OFS)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .hostReqValid(hostReqValid),
    .hostWrite   (hostWrite),
    .hostAddr    (hostAddr),
    .hostReqReady(hostReqReady),
    .hostRspValid(hostRspValid),
    .hostRspReady(hostRspReady),
    .intReqValid (intReqValid),
    .intWe       (intWe),
    .intReqReady (intReqReady),
    .intRspValid (intRspValid),
    .st          (st)
  );

  idx_window_dp #(
    .DATA_W(DATA_W),
    .INT_AW(INT_AW)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .st       (st),
    .hostWdata(hostWdata),
    .intRdata (intRdata),
    .addrQ    (addrQ),
    .wdataQ   (intWdata),
    .rdataQ   (hostRdata)
  );

  assign intAddr = addrQ;
  assign mapSel  = addrQ[INT_AW-1:MAP_LSB];
  assign bankSel = addrQ[MAP_LSB-1:BANK_LSB];

  // R8: response data does not move while the host holds off
  p_rdata_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (hostRspValid && !hostRspReady) |=> $stable(hostRdata));

  // R9: an unaccepted internal request is held unchanged
  p_int_req_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (intReqValid && !intReqReady) |=>
      (intReqValid && $stable(intAddr) && $stable(intWdata) && $stable(intWe)));

endmodule

// File: tb/idx_window_bridge_test.sv
module idx_window_bridge_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostReqValid = 1'b0;
  logic        hostReqReady;
  logic        hostWrite = 1'b0;
  logic [7:0]  hostAddr = '0;
  logic [31:0] hostWdata = '0;
  logic        hostRspValid;
  logic        hostRspReady = 1'b0;
  logic [31:0] hostRdata;
  logic        intReqValid;
  logic        intReqReady = 1'b0;
  logic        intWe;
  logic [27:0] intAddr;
  logic [31:0] intWdata;
  logic        intRspValid = 1'b0;
  logic [31:0] intRdata = '0;
  logic [1:0]  mapSel;
  logic [1:0]  bankSel;

  int checks = 0;
  int errors = 0;

  // internal responder bookkeeping
  int          stallCycles = 0;
  int          rdLat = 1;
  int          reqCount = 0;
  logic [27:0] lastAddr = '0;
  logic        lastWe = 1'b0;
  logic [31:0] lastWdata = '0;
  logic        holdBroken = 1'b0;

  always #10 clk = ~clk;

  idx_window_bridge uut (
    .clk(clk), .rstN(rstN),
    .hostReqValid(hostReqValid), .hostReqReady(hostReqReady),
    .hostWrite(hostWrite), .hostAddr(hostAddr), .hostWdata(hostWdata),
    .hostRspValid(hostRspValid), .hostRspReady(hostRspReady), .hostRdata(hostRdata),
    .intReqValid(intReqValid), .intReqReady(intReqReady), .intWe(intWe),
    .intAddr(intAddr), .intWdata(intWdata),
    .intRspValid(intRspValid), .intRdata(intRdata),
    .mapSel(mapSel), .bankSel(bankSel)
  );

  function automatic logic [31:0] memModel(input logic [27:0] a);
    return {4'hC, a} ^ 32'h0F0F_0F0F;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // internal port model: stalls acceptance, then returns read data later
  initial begin
    forever begin
      @(negedge clk);
      if (intReqValid) begin
        logic [27:0] a0;
        logic [31:0] d0;
        logic        w0;
        a0 = intAddr; d0 = intWdata; w0 = intWe;
        for (int i = 0; i < stallCycles; i++) begin
          @(negedge clk);
          if (!intReqValid || intAddr !== a0 || intWdata !== d0 || intWe !== w0)
            holdBroken = 1'b1;
        end
        reqCount++;
        lastAddr = intAddr; lastWe = intWe; lastWdata = intWdata;
        intReqReady = 1'b1;
        @(negedge clk);
        intReqReady = 1'b0;
        if (!lastWe) begin
          for (int i = 1; i < rdLat; i++) @(negedge clk);
          intRdata = memModel(lastAddr);
          intRspValid = 1'b1;
          @(negedge clk);
          intRspValid = 1'b0;
          intRdata = '0;
        end
      end
    end
  end

  // one host access; rspDelay cycles of response back-pressure
  task automatic hostAccess(input logic wr, input logic [7:0] off, input logic [31:0] wd,
                            input int rspDelay, output logic [31:0] rd);
    @(negedge clk);
    while (!hostReqReady) @(negedge clk);
    hostReqValid = 1'b1; hostWrite = wr; hostAddr = off; hostWdata = wd;
    @(negedge clk);
    hostReqValid = 1'b0;
    while (!hostRspValid) @(negedge clk);
    rd = hostRdata;
    for (int i = 0; i < rspDelay; i++) begin
      @(negedge clk);
      chk("R8 response held", {30'b0, hostRspValid, hostReqReady}, 32'h2);
      chk("R8 data held", hostRdata, rd);
    end
    hostRspReady = 1'b1;
    @(negedge clk);
    hostRspReady = 1'b0;
  endtask

  task automatic testReset();
    logic [31:0] rd;
    chk("R1 no response", {31'b0, hostRspValid}, 0);
    chk("R1 no internal req", {31'b0, intReqValid}, 0);
    chk("R1 ready", {31'b0, hostReqReady}, 1);
    chk("R1 address zero", {4'b0, intAddr}, 0);
    hostAccess(1'b0, 8'h00, 0, 0, rd);
    chk("R1 index read", rd, 0);
  endtask

  task automatic testIndex();
    logic [31:0] rd;
    hostAccess(1'b1, 8'h00, 32'hF9A5_1234, 0, rd);
    chk("R2 write response", rd, 0);
    hostAccess(1'b0, 8'h00, 0, 0, rd);
    chk("R2 index readback", rd, 32'h09A5_1234);
    chk("R6 map", {30'b0, mapSel}, 2);
    chk("R6 bank", {30'b0, bankSel}, 1);
  endtask

  task automatic testDataWrite();
    logic [31:0] rd;
    int n0;
    n0 = reqCount;
    stallCycles = 3;
    hostAccess(1'b1, 8'h10, 32'hDEAD_BEEF, 0, rd);
    chk("R3 one request", reqCount - n0, 1);
    chk("R3 we", {31'b0, lastWe}, 1);
    chk("R3 addr", {4'b0, lastAddr}, 32'h09A5_1234);
    chk("R3 wdata", lastWdata, 32'hDEAD_BEEF);
    chk("R3 response", rd, 0);
    chk("R9 request held", {31'b0, holdBroken}, 0);
  endtask

  task automatic testDataRead();
    logic [31:0] rd;
    int n0;
    n0 = reqCount;
    stallCycles = 1; rdLat = 4;
    hostAccess(1'b0, 8'h10, 0, 3, rd);
    chk("R4 one request", reqCount - n0, 1);
    chk("R4 we", {31'b0, lastWe}, 0);
    chk("R4 data", rd, memModel(28'h9A5_1234));
    stallCycles = 0; rdLat = 1;
    hostAccess(1'b0, 8'h10, 0, 0, rd);
    chk("R5 repeat addr", {4'b0, lastAddr}, 32'h09A5_1234);
    chk("R5 repeat data", rd, memModel(28'h9A5_1234));
    hostAccess(1'b0, 8'h00, 0, 0, rd);
    chk("R5 index kept", rd, 32'h09A5_1234);
  endtask

  task automatic testOther();
    logic [31:0] rd;
    int n0;
    n0 = reqCount;
    hostAccess(1'b1, 8'h04, 32'h1234_5678, 0, rd);
    chk("R7 write response", rd, 0);
    hostAccess(1'b0, 8'h08, 0, 0, rd);
    chk("R7 read zero 08", rd, 0);
    hostAccess(1'b0, 8'h14, 0, 0, rd);
    chk("R7 read zero 14", rd, 0);
    chk("R7 no requests", reqCount - n0, 0);
    hostAccess(1'b0, 8'h00, 0, 0, rd);
    chk("R7 index unchanged", rd, 32'h09A5_1234);
  endtask

  task automatic testSecondIndex();
    logic [31:0] rd;
    hostAccess(1'b1, 8'h00, 32'hFEDC_BA98, 0, rd);
    chk("R6 map 11", {30'b0, mapSel}, 3);
    chk("R6 bank 10", {30'b0, bankSel}, 2);
    stallCycles = 2; rdLat = 2;
    hostAccess(1'b0, 8'h10, 0, 1, rd);
    chk("R4 new index data", rd, memModel(28'hEDC_BA98));
    chk("R9 request held", {31'b0, holdBroken}, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testIndex();
    testDataWrite();
    testDataRead();
    testOther();
    testSecondIndex();
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule